// File: doc/BRIEF.md
# Cache Range Maintenance Command Splitter

This block sits between software-visible cache maintenance requests and a cache engine that only understands bounded range commands with inclusive ends. A request names an operation (invalidate, clean or flush) and a half-open byte interval `[start, end)`. The block turns it into a series of commands. Each command covers whole 32-byte lines. It spans at most 1024 bytes and never leaves a 4096-byte page.

For invalidation, the block protects partial lines at either edge of the interval. Each such edge line gets a single-line clean-and-invalidate command instead of a plain invalidate, so neighbouring data in that line is not lost. A write-through mode input tells the block that the cache can never hold dirty lines. In that mode all clean work is dropped.

Commands leave on a valid/ready channel. The request side accepts work only when the block is idle. A one-cycle completion pulse marks the end of every request, including requests that produce no command at all.

Top module: `range_maint_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: An invalidate or flush body chunk has the following bounds. Its exclusive end is the smallest of three values: the body end, the chunk start plus 1024, and the next 4096-byte page boundary above the chunk start. The command carries `cmd_first` equal to the chunk start and `cmd_last` equal to the exclusive end minus 32. Invalidate body chunks use `cmd_kind` 2 (range invalidate).
- R3: For an invalidate request (`req_op` 0) whose start is not a multiple of 32, the first command is a single-line clean-and-invalidate. It has `cmd_kind` 0 and `cmd_first` = `cmd_last` = start rounded down to 32. The body then begins at the next 32-byte boundary.
- R4: For invalidate, the block checks the end after the start adjustment of R3. If the adjusted start is still below the end and the end is not a multiple of 32, a kind-0 command is issued for the line holding the end. This command follows any R3 command and comes before all body chunks. The body end is then rounded down to 32.
- R5: A clean request (`req_op` 1) without write-through first rounds the start down and the end up to multiples of 32. It then emits only kind-1 (range clean) chunks bounded as in R2.
- R6: A flush request (`req_op` 2) without write-through first rounds the start down and the end up to multiples of 32. For every chunk it emits a kind-1 command and then a kind-2 command with identical bounds.
- R7: With `wt_mode` high when the request is accepted, a clean request emits no commands. A flush request emits only its kind-2 chunks.
- R8: `done` is high for exactly one cycle, in the cycle after the last command handshake of a request. For a request with no commands, `done` rises in the second cycle after acceptance. `done` is never high together with `cmd_valid`.
- R9: `req_ready` is 1 only while the block is idle. A `req_valid` presented while busy produces no extra commands.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_kind`, `cmd_first` and `cmd_last` stay unchanged into the next cycle.
- R11: `req_op` 3 is reserved. It emits no commands and only produces the `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when both high |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 reserved |
| req_start | input | 32 | First byte of the interval |
| req_end | input | 32 | Byte just past the interval |
| wt_mode | input | 1 | Write-through mode, sampled at acceptance |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_kind | output | 2 | 0 line clean-invalidate, 1 range clean, 2 range invalidate |
| cmd_first | output | 32 | First line address of the command |
| cmd_last | output | 32 | Last line address of the command (inclusive) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Wrong internal state shows up at the command port itself. A stale cursor repeats or skips a chunk. A wrong clip lets a command cross a page or exceed 1024 bytes. A lost phase flag breaks the clean-then-invalidate pairing. Each of these appears at the very next handshake, because the bench compares every accepted command against its own expected list. A bad end-of-work decision moves the `done` pulse off its exact expected cycle, or leaves commands outstanding when `done` fires. That error is caught in the cycle it happens. Stalls from a pseudo-random `cmd_ready` expose any output change while the command is held.

// File: rtl/rms_pkg.sv
package rms_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_LINE_CI   = 2'd0,
        K_CLEAN_RNG = 2'd1,
        K_INV_RNG   = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e kind;
        addr_t first;
        addr_t last;
    } cmd_t;

    typedef struct packed {
        logic  head_pend;
        addr_t head_addr;
        logic  tail_pend;
        addr_t tail_addr;
        addr_t body_start;
        addr_t body_end;
        logic  do_clean;
        logic  do_inv;
    } plan_t;

    function automatic addr_t align_down(addr_t a, int unsigned line_bytes);
        return a & ~addr_t'(line_bytes - 1);
    endfunction

    function automatic addr_t align_up(addr_t a, int unsigned line_bytes);
        return (a + addr_t'(line_bytes - 1)) & ~addr_t'(line_bytes - 1);
    endfunction

    function automatic logic off_line(addr_t a, int unsigned line_bytes);
        return |(a & addr_t'(line_bytes - 1));
    endfunction

endpackage

// File: rtl/rms_plan.sv
module rms_plan
    import rms_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32
) (
    input  op_e   op,
    input  addr_t lo,
    input  addr_t hi,
    input  logic  wt,
    output plan_t plan
);
    addr_t lo_adj;
    logic  lo_part;
    logic  hi_part;

    always_comb begin
        plan    = '0;
        lo_part = off_line(lo, LINE_BYTES);
        hi_part = off_line(hi, LINE_BYTES);
        lo_adj  = lo_part ? align_down(lo, LINE_BYTES) + addr_t'(LINE_BYTES) : lo;
        case (op)
            OP_INV: begin
                // R3 partial leading line, R4 partial trailing line
                plan.head_pend  = lo_part;
                plan.head_addr  = align_down(lo, LINE_BYTES);
                plan.tail_pend  = (lo_adj < hi) && hi_part;
                plan.tail_addr  = align_down(hi, LINE_BYTES);
                plan.body_start = lo_adj;
                plan.body_end   = hi_part ? align_down(hi, LINE_BYTES) : hi;
                plan.do_inv     = 1'b1;
            end
            OP_CLEAN: begin
                if (!wt) begin
                    plan.body_start = align_down(lo, LINE_BYTES);
                    plan.body_end   = align_up(hi, LINE_BYTES);
                    plan.do_clean   = 1'b1;
                end
            end
            OP_FLUSH: begin
                plan.body_start = align_down(lo, LINE_BYTES);
                plan.body_end   = align_up(hi, LINE_BYTES);
                plan.do_clean   = !wt;
                plan.do_inv     = 1'b1;
            end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/rms_chunk.sv
module rms_chunk
    import rms_pkg::*;
#(
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  addr_t cur,
    input  addr_t lim,
    output addr_t nxt
);
    localparam int unsigned WW = ADDR_W + 1;

    logic [WW-1:0] by_lim;
    logic [WW-1:0] by_max;
    logic [WW-1:0] by_page;
    logic [WW-1:0] pick;

    always_comb begin
        by_lim  = {1'b0, lim};
        by_max  = {1'b0, cur} + WW'(MAX_BYTES);
        by_page = ({1'b0, cur} | WW'(PAGE_BYTES - 1)) + WW'(1);
        pick    = by_lim;
        if (by_max < pick)  pick = by_max;
        if (by_page < pick) pick = by_page;
        nxt     = ADDR_W'(pick);
    end
endmodule

// File: rtl/rms_seq.sv
module rms_seq
    import rms_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    output logic  req_ready,
    input  plan_t plan_in,
    output logic  cmd_valid,
    input  logic  cmd_ready,
    output cmd_t  cmd,
    output logic  done
);
    localparam int unsigned LB_W = $clog2(LINE_BYTES);
    localparam int unsigned PG_W = $clog2(PAGE_BYTES);

    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e   state;
    plan_t work;
    addr_t cur;
    logic  inv_phase;

    addr_t chunk_end;
    cmd_t  nx_cmd;
    logic  nx_have;
    logic  nx_head;
    logic  nx_tail;
    addr_t nx_cur;
    logic  nx_phase;
    logic  slot_free;

    rms_chunk #(
        .MAX_BYTES (MAX_BYTES),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_chunk (
        .cur(cur),
        .lim(work.body_end),
        .nxt(chunk_end)
    );

    always_comb begin
        nx_cmd   = cmd;
        nx_have  = 1'b1;
        nx_head  = work.head_pend;
        nx_tail  = work.tail_pend;
        nx_cur   = cur;
        nx_phase = inv_phase;
        if (work.head_pend) begin
            nx_cmd  = '{kind: K_LINE_CI, first: work.head_addr, last: work.head_addr};
            nx_head = 1'b0;
        end else if (work.tail_pend) begin
            nx_cmd  = '{kind: K_LINE_CI, first: work.tail_addr, last: work.tail_addr};
            nx_tail = 1'b0;
        end else if (cur < work.body_end) begin
            nx_cmd.first = cur;
            nx_cmd.last  = chunk_end - addr_t'(LINE_BYTES);
            if (work.do_clean && !inv_phase) begin
                nx_cmd.kind = K_CLEAN_RNG;
                if (work.do_inv) nx_phase = 1'b1;
                else             nx_cur   = chunk_end;
            end else begin
                nx_cmd.kind = K_INV_RNG;
                nx_phase    = 1'b0;
                nx_cur      = chunk_end;
            end
        end else begin
            nx_have = 1'b0;
        end
    end

    assign slot_free = !cmd_valid || cmd_ready;
    assign req_ready = (state == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            work      <= '0;
            cur       <= '0;
            inv_phase <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        work      <= plan_in;
                        cur       <= plan_in.body_start;
                        inv_phase <= 1'b0;
                        state     <= S_RUN;
                    end
                end
                default: begin
                    if (slot_free) begin
                        if (nx_have) begin
                            cmd            <= nx_cmd;
                            cmd_valid      <= 1'b1;
                            work.head_pend <= nx_head;
                            work.tail_pend <= nx_tail;
                            cur            <= nx_cur;
                            inv_phase      <= nx_phase;
                        end else begin
                            cmd_valid <= 1'b0;
                            done      <= 1'b1;
                            state     <= S_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R10: a stalled command is held
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd)));

    // R8: completion is a single-cycle pulse away from any command
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);

    // R9: no request is taken while commands are in flight
    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R2: range commands are line aligned, bounded and inside one page
    a_r2_bounds: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind != K_LINE_CI) |->
            (cmd.first[ADDR_W-1:PG_W] == cmd.last[ADDR_W-1:PG_W]) &&
            (cmd.last >= cmd.first) &&
            ((cmd.last - cmd.first) < addr_t'(MAX_BYTES)) &&
            (cmd.first[LB_W-1:0] == '0));

    // R3 / R4: single-line commands name exactly one aligned line
    a_r3_line: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_LINE_CI) |->
            (cmd.first == cmd.last) && (cmd.first[LB_W-1:0] == '0));
endmodule

// File: rtl/range_maint_splitter.sv
module range_maint_splitter
    import rms_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              wt_mode,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_first,
    output logic [ADDR_W-1:0] cmd_last,
    output logic              done
);
    plan_t plan;
    cmd_t  cmd;

    rms_plan #(.LINE_BYTES(LINE_BYTES)) u_plan (
        .op  (op_e'(req_op)),
        .lo  (req_start),
        .hi  (req_end),
        .wt  (wt_mode),
        .plan(plan)
    );

    rms_seq #(
        .LINE_BYTES(LINE_BYTES),
        .MAX_BYTES (MAX_BYTES),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .plan_in  (plan),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd      (cmd),
        .done     (done)
    );

    assign cmd_kind  = cmd.kind;
    assign cmd_first = cmd.first;
    assign cmd_last  = cmd.last;
endmodule

// File: tb/sim_range_maint_splitter.sv
module sim_range_maint_splitter;
    localparam longint LB = 32;
    localparam longint MX = 1024;
    localparam longint PG = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        wt_mode = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_first;
    logic [31:0] cmd_last;
    logic        done;

    always #4 clk = ~clk;

    range_maint_splitter u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_start(req_start), .req_end(req_end), .wt_mode(wt_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_first(cmd_first), .cmd_last(cmd_last), .done(done)
    );

    int total = 0;
    int bad = 0;
    longint qk[$];
    longint qf[$];
    longint ql[$];
    string  qt[$];
    int  done_in = 0;
    int  issued = 0;
    bit  rdy_rand = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit  stalled = 0;
    logic [1:0]  sv_kind;
    logic [31:0] sv_first;
    logic [31:0] sv_last;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic longint cend(longint s, longint e);
        longint r = e;
        longint pg = (s | (PG - 1)) + 1;
        if (r > s + MX) r = s + MX;
        if (r > pg) r = pg;
        return r;
    endfunction

    task automatic push(longint k, longint f, longint l, string tag);
        qk.push_back(k); qf.push_back(f); ql.push_back(l); qt.push_back(tag);
    endtask

    task automatic model(int op, longint s, longint e, bit wt);
        longint r;
        if (op == 0) begin
            if (s % LB != 0) begin
                push(0, s & ~(LB - 1), s & ~(LB - 1), "R3");
                s = (s | (LB - 1)) + 1;
            end
            if (s < e && e % LB != 0) begin
                push(0, e & ~(LB - 1), e & ~(LB - 1), "R4");
                e = e & ~(LB - 1);
            end
            while (s < e) begin
                r = cend(s, e);
                push(2, s, r - LB, "R2");
                s = r;
            end
        end else if (op == 1 || op == 2) begin
            s = s & ~(LB - 1);
            e = (e + LB - 1) & ~(LB - 1);
            while (s < e) begin
                r = cend(s, e);
                if (!wt) push(1, s, r - LB, (op == 1) ? "R5" : "R6");
                if (op == 2) push(2, s, r - LB, wt ? "R7" : "R6");
                s = r;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
        if (done || done_in == 1)
            chk(done && done_in == 1, "R8", "done timing", longint'(done), longint'(done_in == 1));
        if (done_in > 0) done_in--;
        if (stalled)
            chk(cmd_valid && cmd_kind == sv_kind && cmd_first == sv_first && cmd_last == sv_last,
                "R10", "held command", longint'(cmd_first), longint'(sv_first));
        stalled  = cmd_valid && !cmd_ready;
        sv_kind  = cmd_kind;
        sv_first = cmd_first;
        sv_last  = cmd_last;
        if (cmd_valid && cmd_ready) begin
            issued++;
            if (qk.size() == 0) begin
                chk(0, "R9", "unexpected command", longint'(cmd_first), 0);
            end else begin
                chk(longint'(cmd_kind) == qk[0], qt[0], "kind", longint'(cmd_kind), qk[0]);
                chk(longint'(cmd_first) == qf[0] && longint'(cmd_last) == ql[0], qt[0],
                    "first/last", {longint'(cmd_first), 32'h0} | longint'(cmd_last),
                    (qf[0] << 32) | ql[0]);
                void'(qk.pop_front()); void'(qf.pop_front());
                void'(ql.pop_front()); void'(qt.pop_front());
                if (qk.size() == 0) done_in = 1;
            end
        end
    endtask

    task automatic send(int op, longint s, longint e, bit wt, string tag, bit intrude);
        int guard = 0;
        int exp_n;
        while (!req_ready) step();
        chk(req_ready, "R9", "ready when idle", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_start = 32'(s);
        req_end   = 32'(e);
        wt_mode   = wt;
        model(op, s, e, wt);
        exp_n  = qk.size();
        issued = 0;
        if (exp_n == 0) done_in = 2;
        step();
        req_valid = 1'b0;
        wt_mode   = 1'b0;
        while (qk.size() > 0 || done_in > 0) begin
            step();
            guard++;
            if (intrude && guard == 3) begin
                // R9: a request offered while busy must be ignored
                chk(!req_ready, "R9", "busy not ready", longint'(req_ready), 0);
                req_valid = 1'b1; req_op = 2'd2; req_start = 32'h8000; req_end = 32'h9000;
            end
            if (intrude && guard == 4) req_valid = 1'b0;
            if (guard > 5000) begin
                chk(0, tag, "request timed out", 0, 0);
                break;
            end
        end
        step();
        chk(issued == exp_n, tag, "command count", issued, exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", longint'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", longint'(cmd_valid), 0);
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        rst = 1'b0;
        step();

        send(0, 'h1F00, 'h2A00, 0, "R2", 0);   // crosses a page, then 1024-byte caps
        send(0, 'h0105, 'h0543, 0, "R4", 0);   // both edges partial
        send(0, 'h0104, 'h0110, 0, "R3", 0);   // inside one line: head only
        send(0, 'h0200, 'h0210, 0, "R4", 0);   // aligned start, partial end, same line
        send(0, 'h0300, 'h0300, 0, "R8", 0);   // empty interval
        send(1, 'h3FF1, 'h4421, 0, "R5", 0);
        send(1, 'h0000, 'h0800, 1, "R7", 0);   // clean in write-through: nothing
        send(2, 'h0FC0, 'h1080, 0, "R6", 0);
        send(2, 'h5010, 'h5C00, 1, "R7", 0);
        send(3, 'h0000, 'h1000, 0, "R11", 0);  // reserved op
        rdy_rand = 1;
        send(2, 'h6E00, 'h7A20, 0, "R10", 1);  // stalls plus R9 intrusion
        send(0, 'hA00F, 'hB7F1, 0, "R2", 0);
        send(1, 'hC000, 'hD001, 0, "R5", 0);
        rdy_rand = 0;
        step();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule